// File: doc/BRIEF.md
# Five-Port Mesh Wormhole Router with Outbound Hardwall

This block is the switching element of one packet network in a two-dimensional mesh of cores. It has five ports: one for each compass neighbour and one for the local processor. Each port carries a 32-bit word in each direction, with valid/ready flow control. The first word of every packet is a header. It names the destination tile and how many payload words follow. The router uses that header to pick an output by dimension-ordered routing. It then streams the packet through as a wormhole: the output stays reserved for that input until the last payload word has gone.

Every output link can be fenced off by a mask bit. When a header asks for a fenced output, the router does not forward the packet. It swallows the whole packet at the input and sets a sticky per-output flag, and any set flag drives an interrupt line. Software clears a flag by pulsing the matching clear bit. Each input buffers up to four words, and no word is ever lost to backpressure.

Top module: `mesh_router`

## Requirements
- R1: Port index encoding is 0 = local processor, 1 = north (+Y), 2 = south (-Y), 3 = east (+X), 4 = west (-X). Header layout is destination X in bits [31:29], destination Y in bits [28:26], and the payload word count minus one in bits [6:0]. The header leaves the router unchanged.
- R2: A header whose destination X differs from the router's own X leaves on east when it is larger and on west when it is smaller, whatever its Y.
- R3: A header whose destination X matches leaves on north when its Y is larger, on south when its Y is smaller, and on the local port when both coordinates match.
- R4: A packet leaves as its header followed by exactly (bits[6:0] + 1) payload words, in order and unaltered, all on the header's output. No word of another packet is interleaved. Packets of up to 128 payload words are carried.
- R5: While an output presents a word that is not accepted (valid high, ready low), the next cycle shows the same word with valid still high.
- R6: Each output serves contending inputs round-robin. After a packet from input i, the next packet granted goes to the first requesting input after i in cyclic index order. After reset, input 0 has first priority.
- R7: Each input holds up to four words. Its ready is low while four words are held, and it never takes a fifth word.
- R8: A packet whose header selects an output with its hardwall mask bit set is consumed and discarded at its input, header and payload alike. Nothing of it appears on any output, and later packets on that input flow normally.
- R9: Discarding a packet sets the sticky flag bit of the fenced output. The flag stays set until a one is pulsed on the same bit of the clear input. A new block in the same cycle wins over a clear. The interrupt output is the OR of all flag bits.
- R10: During and right after reset, every output valid is low, every input ready is high, and all flags and the interrupt are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 160 | Inbound words, port p at bits [32p+31:32p] |
| in_valid | input | 5 | Inbound word valid, one bit per port |
| in_ready | output | 5 | Inbound buffer has room, one bit per port |
| out_data | output | 160 | Outbound words, port p at bits [32p+31:32p] |
| out_valid | output | 5 | Outbound word valid |
| out_ready | input | 5 | Downstream accepts the outbound word |
| hw_mask | input | 5 | Hardwall fence per output port |
| hw_clr | input | 5 | Write-one-to-clear pulse per flag bit |
| hw_flag | output | 5 | Sticky blocked-attempt flag per output port |
| hw_irq | output | 1 | OR of all flag bits |

## Verification
A corrupted per-input word counter shows up when the next packet begins. The monitor then sees a payload word where it expects a header, or a header where it expects a payload word, and at once finds a bad source tag, a wrong output, or a word mismatch. A stuck output lock freezes that output. Every later packet to it stays in the expected queues, so the drain step fails within its cycle bound. A wrong round-robin pointer shows as a permuted source order in the first contention pattern. A drop state that leaks turns up as a word on the fenced east port during the hardwall phase. A drop state that ends too early shows as a garbage header on some output within a few cycles.

// File: rtl/mesh_rt_pkg.sv
package mesh_rt_pkg;
  localparam int DW = 32;
  localparam int NP = 5;
  localparam int PW = $clog2(NP);
  localparam int XW = 3;
  localparam int YW = 3;
  localparam int LW = 7;
  localparam int CW = LW + 1;

  localparam logic [PW-1:0] P_LOC   = 3'd0;
  localparam logic [PW-1:0] P_NORTH = 3'd1;
  localparam logic [PW-1:0] P_SOUTH = 3'd2;
  localparam logic [PW-1:0] P_EAST  = 3'd3;
  localparam logic [PW-1:0] P_WEST  = 3'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_BODY, ST_DROP} in_st_t;

  function automatic logic [XW-1:0] hdr_x(input logic [DW-1:0] w);
    return w[DW-1 -: XW];
  endfunction

  function automatic logic [YW-1:0] hdr_y(input logic [DW-1:0] w);
    return w[DW-1-XW -: YW];
  endfunction

  // payload words that follow the header (field holds count minus one)
  function automatic logic [CW-1:0] hdr_len(input logic [DW-1:0] w);
    return {1'b0, w[LW-1:0]} + CW'(1);
  endfunction

  // dimension order: X first, then Y, then eject
  function automatic logic [PW-1:0] route_dir(input logic [XW-1:0] dx, input logic [YW-1:0] dy,
                                              input logic [XW-1:0] lx, input logic [YW-1:0] ly);
    if (dx > lx) return P_EAST;
    if (dx < lx) return P_WEST;
    if (dy > ly) return P_NORTH;
    if (dy < ly) return P_SOUTH;
    return P_LOC;
  endfunction

  // {found, index}: first requester after 'last' in cyclic order
  function automatic logic [PW:0] rr_pick(input logic [NP-1:0] req, input logic [PW-1:0] last);
    logic [PW:0] res;
    res = '0;
    for (int k = NP; k >= 1; k--) begin
      int idx;
      idx = (int'(last) + k) % NP;
      if (req[idx]) res = {1'b1, PW'(idx)};
    end
    return res;
  endfunction
endpackage

// File: rtl/rt_in_fifo.sv
module rt_in_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [NW-1:0]    cnt;

  assign full  = (cnt == NW'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = mem[rp];

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= ptr_next(wp);
      if (pop)  rp <= ptr_next(rp);
      cnt <= cnt + NW'(push) - NW'(pop);
    end
  end

  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
  a_r7_no_overflow:  assert property (@(posedge clk) disable iff (!rst_n) cnt <= NW'(DEPTH));
endmodule

// File: rtl/rt_in_ctrl.sv
module rt_in_ctrl
  import mesh_rt_pkg::*;
#(
  parameter int LOC_X = 0,
  parameter int LOC_Y = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_vld,
  input  logic [DW-1:0] head_data,
  input  logic [NP-1:0] hw_mask,
  input  logic          granted,
  input  logic          fire,
  output logic          pop,
  output logic          fwd_vld,
  output logic          req,
  output logic          is_last,
  output logic          drop_hit,
  output logic [PW-1:0] cur_dir
);
  in_st_t        st;
  logic [CW-1:0] rem;
  logic [PW-1:0] dir_q;
  logic [PW-1:0] hdr_dir;
  logic          blocked;
  logic          drop_pop;

  assign hdr_dir  = route_dir(hdr_x(head_data), hdr_y(head_data), XW'(LOC_X), YW'(LOC_Y));
  assign cur_dir  = (st == ST_IDLE) ? hdr_dir : dir_q;
  assign blocked  = hw_mask[hdr_dir];
  assign drop_hit = (st == ST_IDLE) && head_vld && blocked && !granted;
  assign drop_pop = (st == ST_DROP) && head_vld;
  assign req      = (st == ST_IDLE) && head_vld && !blocked;
  assign fwd_vld  = head_vld && ((st == ST_BODY) || ((st == ST_IDLE) && (granted || !blocked)));
  assign is_last  = (st == ST_BODY) && (rem == CW'(1));
  assign pop      = fire || drop_hit || drop_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      rem   <= '0;
      dir_q <= P_LOC;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (drop_hit) begin
            st  <= ST_DROP;
            rem <= hdr_len(head_data);
          end else if (fire) begin
            st    <= ST_BODY;
            rem   <= hdr_len(head_data);
            dir_q <= hdr_dir;
          end
        end
        ST_BODY: begin
          if (fire) begin
            rem <= rem - CW'(1);
            if (rem == CW'(1)) st <= ST_IDLE;
          end
        end
        ST_DROP: begin
          if (drop_pop) begin
            rem <= rem - CW'(1);
            if (rem == CW'(1)) st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8: a packet under discard never reaches an output
  a_r8_drop_silent: assert property (@(posedge clk) disable iff (!rst_n) (st == ST_DROP) |-> !fire);
  // R4: a body word is only moved when an output was granted to this input
  a_r4_fire_granted: assert property (@(posedge clk) disable iff (!rst_n) fire |-> granted);
  a_r4_rem_nonzero: assert property (@(posedge clk) disable iff (!rst_n) (st != ST_IDLE) |-> (rem != '0));
endmodule

// File: rtl/rt_out_arb.sv
module rt_out_arb
  import mesh_rt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] req,
  input  logic          rel,
  output logic          lock,
  output logic [PW-1:0] owner
);
  logic [PW-1:0] last_q;
  logic [PW:0]   pick;

  assign pick = rr_pick(req, last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock   <= 1'b0;
      owner  <= '0;
      last_q <= PW'(NP - 1);
    end else if (!lock) begin
      if (pick[PW]) begin
        lock   <= 1'b1;
        owner  <= pick[PW-1:0];
        last_q <= pick[PW-1:0];
      end
    end else if (rel) begin
      lock <= 1'b0;
    end
  end

  // R6: grant is held from header until tail
  a_r6_owner_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !rel) |=> (lock && $stable(owner)));
  a_r6_release_locked: assert property (@(posedge clk) disable iff (!rst_n) rel |-> lock);
  a_r6_lock_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock && (req != '0)) |=> lock);
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import mesh_rt_pkg::*;
#(
  parameter int LOC_X      = 3,
  parameter int LOC_Y      = 4,
  parameter int FIFO_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP*DW-1:0] in_data,
  input  logic [NP-1:0]    in_valid,
  output logic [NP-1:0]    in_ready,
  output logic [NP*DW-1:0] out_data,
  output logic [NP-1:0]    out_valid,
  input  logic [NP-1:0]    out_ready,
  input  logic [NP-1:0]    hw_mask,
  input  logic [NP-1:0]    hw_clr,
  output logic [NP-1:0]    hw_flag,
  output logic             hw_irq
);
  logic [DW-1:0] head_data [NP];
  logic [NP-1:0] head_vld, fifo_full, fifo_empty, pop;
  logic [NP-1:0] fwd_vld, req, is_last, drop_hit, granted, fire;
  logic [PW-1:0] cur_dir [NP];
  logic [NP-1:0] gmat [NP];      // gmat[o][i]: output o locked to input i
  logic [NP-1:0] gcol [NP];      // gcol[i][o]: same, transposed
  logic [NP-1:0] lock;
  logic [PW-1:0] owner [NP];
  logic [NP-1:0] rel;
  logic [NP-1:0] flag_set;

  for (genvar i = 0; i < NP; i++) begin : g_in
    assign in_ready[i] = !fifo_full[i];
    assign head_vld[i] = !fifo_empty[i];

    rt_in_fifo #(.WIDTH(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (in_valid[i] && !fifo_full[i]),
      .din   (in_data[i*DW +: DW]),
      .pop   (pop[i]),
      .dout  (head_data[i]),
      .full  (fifo_full[i]),
      .empty (fifo_empty[i])
    );

    assign granted[i] = gmat[cur_dir[i]][i];
    assign fire[i]    = fwd_vld[i] && granted[i] && out_ready[cur_dir[i]];

    rt_in_ctrl #(.LOC_X(LOC_X), .LOC_Y(LOC_Y)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .head_vld  (head_vld[i]),
      .head_data (head_data[i]),
      .hw_mask   (hw_mask),
      .granted   (granted[i]),
      .fire      (fire[i]),
      .pop       (pop[i]),
      .fwd_vld   (fwd_vld[i]),
      .req       (req[i]),
      .is_last   (is_last[i]),
      .drop_hit  (drop_hit[i]),
      .cur_dir   (cur_dir[i])
    );

    for (genvar o = 0; o < NP; o++) begin : g_col
      assign gcol[i][o] = gmat[o][i];
    end

    // R4: an input feeds at most one output at a time
    a_r4_single_grant: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gcol[i]));
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    logic [NP-1:0] oreq;
    logic [NP-1:0] oset;
    for (genvar i = 0; i < NP; i++) begin : g_req
      assign oreq[i]    = req[i] && (cur_dir[i] == PW'(o));
      assign oset[i]    = drop_hit[i] && (cur_dir[i] == PW'(o));
      assign gmat[o][i] = lock[o] && (owner[o] == PW'(i));
    end

    rt_out_arb u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (oreq),
      .rel   (rel[o]),
      .lock  (lock[o]),
      .owner (owner[o])
    );

    assign out_valid[o]          = lock[o] && fwd_vld[owner[o]];
    assign out_data[o*DW +: DW]  = head_data[owner[o]];
    assign rel[o]                = out_valid[o] && out_ready[o] && is_last[owner[o]];
    assign flag_set[o]           = |oset;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hw_flag[o] <= 1'b0;
      else        hw_flag[o] <= (hw_flag[o] && !hw_clr[o]) || flag_set[o];
    end

    // R5: a stalled word is held unchanged
    a_r5_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && !out_ready[o]) |=> (out_valid[o] && $stable(out_data[o*DW +: DW])));
    // R9: flag is sticky until cleared
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_flag[o] && !hw_clr[o]) |=> hw_flag[o]);
    // R8: a fenced output never carries a new header
    a_r8_no_fenced_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock[o] && hw_mask[o] && $stable(hw_mask)) |=> !out_valid[o]);
  end

  assign hw_irq = |hw_flag;
endmodule

// File: tb/sim_mesh_router.sv
module sim_mesh_router;
  localparam int NP = 5;
  localparam int DW = 32;
  localparam int LX = 3;
  localparam int LY = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NP*DW-1:0] in_data = '0;
  logic [NP-1:0]    in_valid = '0;
  logic [NP-1:0]    in_ready;
  logic [NP*DW-1:0] out_data;
  logic [NP-1:0]    out_valid;
  logic [NP-1:0]    out_ready = '0;
  logic [NP-1:0]    hw_mask = '0;
  logic [NP-1:0]    hw_clr = '0;
  logic [NP-1:0]    hw_flag;
  logic             hw_irq;

  mesh_router #(.LOC_X(LX), .LOC_Y(LY), .FIFO_DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .hw_mask(hw_mask), .hw_clr(hw_clr), .hw_flag(hw_flag), .hw_irq(hw_irq)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int inj_pct = 100;
  int ready_pct = 100;
  int seq = 0;
  bit wall_phase = 0;
  int east_vld = 0;
  logic [NP-1:0] clr_b = '0;

  logic [31:0] src_q  [NP][$];
  int          code_q [NP][$];
  logic [31:0] expq   [NP][NP][$];
  int          order_q[$];
  int          acc_cnt [NP];
  int          mrem [NP];
  int          msrc [NP];
  bit          prev_stall [NP];
  logic [31:0] prev_d [NP];

  function automatic int exp_route(input int dx, input int dy);
    if (dx != LX) return (dx > LX) ? 3 : 4;
    if (dy != LY) return (dy > LY) ? 1 : 2;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic gen_pkt(input int i, input int dx, input int dy, input int lm1);
    logic [31:0] hdr;
    int dst, code;
    hdr = {dx[2:0], dy[2:0], i[2:0], seq[15:0], lm1[6:0]};
    seq++;
    dst = exp_route(dx, dy);
    code = hw_mask[dst] ? 7 : dst;
    src_q[i].push_back(hdr);
    code_q[i].push_back(code);
    for (int k = 0; k <= lm1; k++) begin
      src_q[i].push_back($urandom);
      code_q[i].push_back(code);
    end
  endtask

  task automatic mon(input int o, input logic [31:0] w);
    logic [31:0] e;
    int s;
    if (mrem[o] == 0) begin
      s = int'(w[25:23]);
      if (s >= NP) begin
        chk(0, "R4 bad source tag", w, 0);
        return;
      end
      // R2 when X differs, R3 otherwise
      if (int'(w[31:29]) != LX) chk(exp_route(w[31:29], w[28:26]) == o, "R2 x-route", o, exp_route(w[31:29], w[28:26]));
      else                      chk(exp_route(w[31:29], w[28:26]) == o, "R3 y-route", o, exp_route(w[31:29], w[28:26]));
      if (expq[s][o].size() == 0) begin
        chk(0, "R4 unexpected header", w, 0);
        return;
      end
      e = expq[s][o].pop_front();
      chk(w == e, "R1 header word", w, e);
      mrem[o] = int'(w[6:0]) + 1;
      msrc[o] = s;
      if (o == 0) order_q.push_back(s);
    end else begin
      if (expq[msrc[o]][o].size() == 0) begin
        chk(0, "R4 unexpected payload", w, 0);
      end else begin
        e = expq[msrc[o]][o].pop_front();
        chk(w == e, "R4 payload word", w, e);
      end
      mrem[o]--;
    end
  endtask

  task automatic step();
    @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      in_valid[i] = (src_q[i].size() != 0) && ($urandom_range(99) < inj_pct);
      in_data[i*DW +: DW] = (src_q[i].size() != 0) ? src_q[i][0] : 32'h0;
    end
    for (int o = 0; o < NP; o++) out_ready[o] = ($urandom_range(99) < ready_pct);
    hw_clr = clr_b;
    #1;
    for (int o = 0; o < NP; o++) begin
      if (prev_stall[o]) chk(out_valid[o] && (out_data[o*DW +: DW] == prev_d[o]), "R5 stall hold",
                             out_data[o*DW +: DW], prev_d[o]);
      prev_stall[o] = out_valid[o] && !out_ready[o];
      prev_d[o] = out_data[o*DW +: DW];
      if (wall_phase && o == 3 && out_valid[o]) east_vld++;
      if (out_valid[o] && out_ready[o]) mon(o, out_data[o*DW +: DW]);
    end
    for (int i = 0; i < NP; i++) begin
      if (in_valid[i] && in_ready[i]) begin
        logic [31:0] w;
        int c;
        w = src_q[i].pop_front();
        c = code_q[i].pop_front();
        acc_cnt[i]++;
        if (c != 7) expq[i][c].push_back(w);
      end
    end
  endtask

  function automatic bit all_empty();
    for (int i = 0; i < NP; i++) begin
      if (src_q[i].size() != 0 || mrem[i] != 0) return 0;
      for (int o = 0; o < NP; o++) if (expq[i][o].size() != 0) return 0;
    end
    return 1;
  endfunction

  task automatic drain(input string tag, input int limit);
    int n;
    n = 0;
    while (!all_empty() && n < limit) begin
      step();
      n++;
    end
    chk(all_empty(), tag, n, limit);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int exp_order[6];
    void'($urandom(32'd4242));
    for (int i = 0; i < NP; i++) begin
      acc_cnt[i] = 0; mrem[i] = 0; msrc[i] = 0; prev_stall[i] = 0; prev_d[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R10 during reset
    chk(out_valid == '0, "R10 out_valid in reset", out_valid, 0);
    chk(in_ready == '1, "R10 in_ready in reset", in_ready, 5'h1f);
    chk(hw_flag == '0 && hw_irq == 1'b0, "R10 flags in reset", {hw_irq, hw_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == '0, "R10 out_valid after reset", out_valid, 0);
    chk(in_ready == '1, "R10 in_ready after reset", in_ready, 5'h1f);

    // R7: four words fill an input while the output is stalled
    ready_pct = 0;
    gen_pkt(1, LX, LY, 7);
    repeat (8) step();
    chk(acc_cnt[1] == 4, "R7 words accepted", acc_cnt[1], 4);
    chk(in_ready[1] == 1'b0, "R7 ready low when full", in_ready[1], 0);
    ready_pct = 100;
    drain("R7 drain", 200);

    // R6: three inputs contend for the local output; last owner was input 1
    ready_pct = 0;
    order_q.delete();
    for (int r = 0; r < 2; r++) begin
      gen_pkt(1, LX, LY, 0);
      gen_pkt(2, LX, LY, 0);
      gen_pkt(4, LX, LY, 0);
    end
    repeat (6) step();
    ready_pct = 100;
    drain("R6 drain", 200);
    exp_order = '{2, 4, 1, 2, 4, 1};
    chk(order_q.size() == 6, "R6 packet count", order_q.size(), 6);
    for (int k = 0; k < 6 && k < order_q.size(); k++)
      chk(order_q[k] == exp_order[k], "R6 round-robin order", order_q[k], exp_order[k]);

    // R4: longest packet, to the west then to the north
    gen_pkt(0, 0, 7, 127);
    gen_pkt(0, LX, 7, 127);
    drain("R4 long packet drain", 2000);

    // R2 R3 R4 R5: random traffic under random backpressure
    inj_pct = 60;
    ready_pct = 70;
    for (int p = 0; p < 25; p++) begin
      for (int i = 0; i < NP; i++) begin
        int lm;
        lm = ($urandom_range(9) == 0) ? 127 : $urandom_range(15);
        gen_pkt(i, $urandom_range(7), $urandom_range(7), lm);
      end
    end
    drain("R4 random drain", 60000);

    // R8 R9: east fenced
    inj_pct = 100;
    ready_pct = 100;
    @(negedge clk);
    hw_mask = 5'b01000;
    wall_phase = 1;
    east_vld = 0;
    gen_pkt(0, 6, LY, 5);
    gen_pkt(0, LX, LY, 2);
    gen_pkt(2, LX, 7, 1);
    gen_pkt(3, 7, 0, 3);
    drain("R8 later packets delivered", 500);
    chk(east_vld == 0, "R8 nothing on fenced output", east_vld, 0);
    chk(hw_flag == 5'b01000, "R9 flag set", hw_flag, 5'b01000);
    chk(hw_irq == 1'b1, "R9 irq high", hw_irq, 1);
    repeat (5) step();
    chk(hw_flag == 5'b01000, "R9 flag sticky", hw_flag, 5'b01000);
    clr_b = 5'b00001;
    step();
    clr_b = '0;
    step();
    chk(hw_flag == 5'b01000, "R9 clear of other bit", hw_flag, 5'b01000);
    clr_b = 5'b01000;
    step();
    clr_b = '0;
    step();
    chk(hw_flag == '0, "R9 flag cleared", hw_flag, 0);
    chk(hw_irq == 1'b0, "R9 irq cleared", hw_irq, 0);
    wall_phase = 0;
    hw_mask = '0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule